// File: doc/BRIEF.md
# Four-State Trellis-Coded 8-PSK Viterbi Decoder

This block decodes a rate 2/3 trellis code in which each pair of data bits becomes one of eight 3-bit phase symbols. One received symbol enters per accepted `in_valid_i` cycle. For each symbol the block does the following. It measures a chord-shaped distance from the symbol to every phase point. It keeps the nearer point of each antipodal pair, which gives four subset metrics. It then runs add-compare-select over four trellis states, with the smallest metric subtracted after every step. Survivor words are kept in a register-exchange path memory.

The matching encoder has two delay bits, d1 and d2, both zero after reset. For input bits x2 and x1 it sends symbol bit 2 = x2, bit 1 = x1 XOR d2, bit 0 = d1. It then updates d1 to x1 XOR d2 and d2 to the old d1. The decoder releases each data word exactly `SURV_DEPTH` accepted symbols after the symbol that carried it. It also raises an error flag when the best path does not match the newest symbol exactly.

Control is a two-state machine. `ST_FILL` counts accepted symbols after reset. Transition FILL_DONE moves to `ST_RUN` when the `SURV_DEPTH`-th symbol is accepted. `ST_RUN` emits one output per accepted symbol. Transition RESET returns to `ST_FILL` from either state.

Top module: `tcm8_viterbi`

## Requirements
- R1: The distance from the received symbol r to point N depends on k = (r - N) mod 8. It is 0, 3, 5, 6, 7 for k = 0, 1, 2, 3, 4, and k and 8 - k give the same value.
- R2: Subset j (j = 0..3) takes the smaller distance of points j and j+4. Its select bit is 1 only when point j+4 is strictly nearer. For any symbol, exactly one subset has metric zero.
- R3: The state index is {d1,d2}. From state {d1,d2}, input x1 leads to state {x1^d2, d1}. The branch uses subset {x1^d2, d1}, and the uncoded bit x2 chooses the member of that subset.
- R4: Each new state metric is the smaller of its two predecessor sums (predecessor metric plus subset metric). On a tie, the predecessor with the lower number is chosen.
- R5: After every step, the smallest new metric is subtracted from all four, so that one metric is zero. Metrics are `PM_W` bits wide.
- R6: `out_valid_o` stays low for the first `SURV_DEPTH` accepted symbols after reset. After that it is high for exactly one cycle following each accepted symbol.
- R7: When `out_valid_o` follows accepted symbol i, `data_o` holds the word decoded for symbol i - `SURV_DEPTH`, with bit 1 = x2 and bit 0 = x1. The word is read from the survivor path of the lowest-metric state, with ties going to the lowest index. On a noise-free stream it equals the sent data.
- R8: `err_o` is updated one cycle after each accepted symbol. It is 1 when the best state's subset metric for that symbol is non-zero, and 0 otherwise.
- R9: A cycle with `in_valid_i` low changes no metric or path. It produces no output pulse, and `data_o` keeps its value.
- R10: Synchronous reset clears metrics, paths and outputs, and returns control to `ST_FILL`.
- R11: A flip of symbol bit 2 alone is not detected: `err_o` stays 0 and the decoded x2 comes out inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | A received symbol is present |
| sym_i | input | 3 | Received phase symbol |
| out_valid_o | output | 1 | Decoded word valid |
| data_o | output | 2 | Decoded word {x2, x1} |
| err_o | output | 1 | Best path mismatched the latest symbol |

## Verification
On an all-zero stream, a single symbol with bit 0 flipped does two things in the same step. It raises the error flag, and it leaves states 0 and 2 with equal new metrics, so the lowest-index tie rule decides which state is best. The bench sends this pattern after the metrics have settled. It expects `err_o` high for that symbol alone and zero words from every later output, which shows that the tie fell to the state on the true path. A second injected flip, on bit 2, shows that an error in the uncoded bit passes through silently.

// File: rtl/tcm8_pkg.sv
package tcm8_pkg;
    localparam int SYM_W   = 3;
    localparam int NUM_PTS = 8;
    localparam int NUM_SUB = 4;
    localparam int NUM_ST  = 4;
    localparam int DIST_W  = 3;

    typedef logic [DIST_W-1:0] dist_t;
    typedef logic [1:0]        word_t;
    typedef logic [1:0]        state_idx_t;

    // quantized chord length 2*sin(k*pi/8), scaled to 3 bits
    function automatic dist_t chord_dist(input logic [SYM_W-1:0] k);
        logic [SYM_W-1:0] fold;
        dist_t            d;
        fold = k[2] ? SYM_W'(4'd8 - {1'b0, k}) : k;
        case (fold)
            3'd0:    d = 3'd0;
            3'd1:    d = 3'd3;
            3'd2:    d = 3'd5;
            3'd3:    d = 3'd6;
            default: d = 3'd7;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/tcm8_branch.sv
module tcm8_branch
    import tcm8_pkg::*;
(
    input  logic [SYM_W-1:0] sym_i,
    output dist_t            sub_metric_o [NUM_SUB],
    output logic [NUM_SUB-1:0] sub_sel_o
);
    dist_t pt_dist [NUM_PTS];

    for (genvar n = 0; n < NUM_PTS; n++) begin : g_pt
        assign pt_dist[n] = chord_dist(sym_i - SYM_W'(n));
    end

    for (genvar j = 0; j < NUM_SUB; j++) begin : g_sub
        always_comb begin
            sub_sel_o[j]    = pt_dist[j+NUM_SUB] < pt_dist[j];
            sub_metric_o[j] = sub_sel_o[j] ? pt_dist[j+NUM_SUB] : pt_dist[j];
        end
    end

    logic [NUM_SUB-1:0] zero_vec;
    always_comb begin
        for (int j = 0; j < NUM_SUB; j++) zero_vec[j] = (sub_metric_o[j] == '0);
        if (!$isunknown(sym_i))
            p_one_zero_subset_r2: assert ($onehot(zero_vec))
                else $error("R2: zero subset count wrong");
    end
endmodule

// File: rtl/tcm8_acs.sv
module tcm8_acs
    import tcm8_pkg::*;
#(
    parameter int PM_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    input  dist_t            sub_metric_i [NUM_SUB],
    output logic [NUM_ST-1:0] dec_o,
    output state_idx_t       best_o
);
    localparam int SUM_W = PM_W + 1;
    localparam logic [SUM_W-1:0] PM_MAX = SUM_W'((1 << PM_W) - 1);

    logic [PM_W-1:0]  pm_q   [NUM_ST];
    logic [PM_W-1:0]  pm_d   [NUM_ST];
    logic [SUM_W-1:0] raw    [NUM_ST];
    logic [SUM_W-1:0] min_v;
    logic [SUM_W-1:0] diff   [NUM_ST];

    // next state {a,b} has predecessors {b,0} and {b,1}
    for (genvar s = 0; s < NUM_ST; s++) begin : g_state
        localparam int P0 = (s % 2) * 2;
        localparam int P1 = P0 + 1;
        logic [SUM_W-1:0] sum0, sum1;
        always_comb begin
            sum0     = {1'b0, pm_q[P0]} + SUM_W'(sub_metric_i[s]);
            sum1     = {1'b0, pm_q[P1]} + SUM_W'(sub_metric_i[s]);
            dec_o[s] = sum1 < sum0;
            raw[s]   = dec_o[s] ? sum1 : sum0;
        end
    end

    always_comb begin
        min_v  = raw[0];
        best_o = '0;
        for (int s = 1; s < NUM_ST; s++) begin
            if (raw[s] < min_v) begin
                min_v  = raw[s];
                best_o = state_idx_t'(s);
            end
        end
        for (int s = 0; s < NUM_ST; s++) begin
            diff[s] = raw[s] - min_v;
            pm_d[s] = (diff[s] > PM_MAX) ? PM_MAX[PM_W-1:0] : diff[s][PM_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_ST; s++) pm_q[s] <= '0;
        end else if (adv_i) begin
            for (int s = 0; s < NUM_ST; s++) pm_q[s] <= pm_d[s];
        end
    end

    p_norm_zero_r5: assert property (@(posedge clk) disable iff (rst)
        $past(adv_i) |-> (pm_q[0] == '0 || pm_q[1] == '0 || pm_q[2] == '0 || pm_q[3] == '0))
        else $error("R5: no zero metric after step");

    p_best_zero_r7: assert property (@(posedge clk) disable iff (rst)
        adv_i |=> pm_q[$past(best_o)] == '0)
        else $error("R7: best state metric not zero");
endmodule

// File: rtl/tcm8_survivor.sv
module tcm8_survivor
    import tcm8_pkg::*;
#(
    parameter int DEPTH = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adv_i,
    input  logic [NUM_ST-1:0]  dec_i,
    input  logic [NUM_SUB-1:0] sub_sel_i,
    input  state_idx_t         best_i,
    output word_t              old_word_o
);
    typedef logic [DEPTH-1:0][1:0] path_t;

    path_t path_q [NUM_ST];
    path_t path_d [NUM_ST];

    for (genvar s = 0; s < NUM_ST; s++) begin : g_path
        localparam logic A = 1'(s / 2);
        localparam logic B = 1'(s % 2);
        state_idx_t pred;
        word_t      word;
        always_comb begin
            pred      = {B, dec_i[s]};
            word      = {sub_sel_i[s], A ^ dec_i[s]};
            path_d[s] = {path_q[pred][DEPTH-2:0], word};
        end
    end

    state_idx_t best_pred;
    always_comb begin
        best_pred  = {best_i[0], dec_i[best_i]};
        old_word_o = path_q[best_pred][DEPTH-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_ST; s++) path_q[s] <= '0;
        end else if (adv_i) begin
            for (int s = 0; s < NUM_ST; s++) path_q[s] <= path_d[s];
        end
    end

    p_path_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> $stable(path_q[0]) && $stable(path_q[3]))
        else $error("R9: path changed without symbol");
endmodule

// File: rtl/tcm8_viterbi.sv
module tcm8_viterbi
    import tcm8_pkg::*;
#(
    parameter int SURV_DEPTH = 12,
    parameter int PM_W       = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid_i,
    input  logic [SYM_W-1:0] sym_i,
    output logic             out_valid_o,
    output logic [1:0]       data_o,
    output logic             err_o
);
    localparam int CNT_W = $clog2(SURV_DEPTH + 1);
    localparam logic [CNT_W-1:0] LAST_FILL = CNT_W'(SURV_DEPTH - 1);

    typedef enum logic {ST_FILL, ST_RUN} ctl_state_t;

    ctl_state_t        state_q, state_d;
    logic [CNT_W-1:0]  fill_q, fill_d;

    dist_t              sub_metric [NUM_SUB];
    logic [NUM_SUB-1:0] sub_sel;
    logic [NUM_ST-1:0]  dec;
    state_idx_t         best;
    word_t              old_word;
    logic               err_d;

    tcm8_branch u_branch (
        .sym_i        (sym_i),
        .sub_metric_o (sub_metric),
        .sub_sel_o    (sub_sel)
    );

    tcm8_acs #(.PM_W(PM_W)) u_acs (
        .clk          (clk),
        .rst          (rst),
        .adv_i        (in_valid_i),
        .sub_metric_i (sub_metric),
        .dec_o        (dec),
        .best_o       (best)
    );

    tcm8_survivor #(.DEPTH(SURV_DEPTH)) u_surv (
        .clk        (clk),
        .rst        (rst),
        .adv_i      (in_valid_i),
        .dec_i      (dec),
        .sub_sel_i  (sub_sel),
        .best_i     (best),
        .old_word_o (old_word)
    );

    assign err_d = sub_metric[best] != '0;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        fill_d  = fill_q;
        unique case (state_q)
            ST_FILL: begin
                if (in_valid_i) begin
                    if (fill_q == LAST_FILL) state_d = ST_RUN;
                    else                     fill_d  = fill_q + 1'b1;
                end
            end
            ST_RUN: begin
                state_d = ST_RUN;
            end
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o <= 1'b0;
            data_o      <= '0;
            err_o       <= 1'b0;
        end else if (in_valid_i) begin
            out_valid_o <= (state_q == ST_RUN);
            data_o      <= old_word;
            err_o       <= err_d;
        end else begin
            out_valid_o <= 1'b0;
        end
    end

    p_quiet_fill_r6: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_FILL |=> !out_valid_o)
        else $error("R6: output during fill");

    p_out_needs_in_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid_o) |-> $past(in_valid_i))
        else $error("R6: output without symbol");

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid_i |=> !out_valid_o && $stable(data_o))
        else $error("R9: idle cycle changed output");
endmodule

// File: tb/tcm8_viterbi_tb.sv
module tcm8_viterbi_tb;
    localparam int DEPTH = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [2:0] sym = 3'd0;
    logic       out_valid;
    logic [1:0] data;
    logic       err;

    int n_chk  = 0;
    int n_fail = 0;
    int nacc   = 0;
    logic d1 = 1'b0, d2 = 1'b0;
    logic [1:0] hist [0:255];

    // {gap, x2, x1}
    localparam logic [2:0] VEC [40] = '{
        3'd3, 3'd1, 3'd6, 3'd0, 3'd2, 3'd7, 3'd5, 3'd1, 3'd0, 3'd3,
        3'd2, 3'd6, 3'd1, 3'd4, 3'd3, 3'd0, 3'd7, 3'd2, 3'd1, 3'd5,
        3'd0, 3'd3, 3'd3, 3'd6, 3'd2, 3'd1, 3'd4, 3'd7, 3'd0, 3'd2,
        3'd1, 3'd3, 3'd5, 3'd2, 3'd0, 3'd6, 3'd3, 3'd1, 3'd2, 3'd0
    };

    tcm8_viterbi #(.SURV_DEPTH(DEPTH), .PM_W(5)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .in_valid_i  (in_valid),
        .sym_i       (sym),
        .out_valid_o (out_valid),
        .data_o      (data),
        .err_o       (err)
    );

    always #5 clk = ~clk;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive one symbol at a negedge, sample at the next negedge
    task automatic accept(input logic x2, input logic x1, input logic [2:0] flip,
                          input logic exp_err, input logic [1:0] exp_word);
        logic [2:0] s;
        s = {x2, x1 ^ d2, d1};
        d2 = d1;
        d1 = x1 ^ s[1] ^ x1 ^ x1;
        d1 = s[1];
        hist[nacc] = exp_word;
        in_valid = 1'b1;
        sym = s ^ flip;
        @(negedge clk);
        in_valid = 1'b0;
        if (nacc < DEPTH) begin
            chk(out_valid == 1'b0, "R6 fill", int'(out_valid), 0);
        end else begin
            chk(out_valid == 1'b1, "R6 pulse", int'(out_valid), 1);
            chk(data == hist[nacc-DEPTH], "R7 R3 word", int'(data), int'(hist[nacc-DEPTH]));
        end
        chk(err == exp_err, "R8 err", int'(err), int'(exp_err));
        nacc++;
    endtask

    task automatic idle_cycle();
        logic [1:0] prev;
        prev = data;
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 no pulse", int'(out_valid), 0);
        chk(data == prev, "R9 data held", int'(data), int'(prev));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0 && err == 1'b0 && data == 2'b00, "R10 reset",
            int'({out_valid, err, data}), 0);
        rst = 1'b0;
        d1 = 1'b0;
        d2 = 1'b0;
        nacc = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // noise-free data walk with occasional idle cycles (R3, R6, R7, R8, R9)
        for (int i = 0; i < 40; i++) begin
            if (VEC[i][2]) idle_cycle();
            accept(VEC[i][1], VEC[i][0], 3'b000, 1'b0, VEC[i][1:0]);
        end
        idle_cycle();

        // reset in mid-run, then fill restarts (R10, R6)
        do_reset();

        // all-zero stream: bit-0 flip at 10 (R1, R2, R4, R5, R8), bit-2 flip at 20 (R11)
        for (int i = 0; i < 40; i++) begin
            if (i == 10)
                accept(1'b0, 1'b0, 3'b001, 1'b1, 2'b00);
            else if (i == 20)
                accept(1'b0, 1'b0, 3'b100, 1'b0, 2'b10);
            else
                accept(1'b0, 1'b0, 3'b000, 1'b0, 2'b00);
        end
        chk(hist[20] == 2'b10, "R11 uncoded flip recorded", int'(hist[20]), 2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule